// File: doc/BRIEF.md
# Latched 64-bit Timebase Counter

This block keeps a 64-bit up-counter that starts at zero after reset. Software reaches it through an APB slave register window with 32-bit data. The counter advances on one of two count events: a single-cycle tick pulse from outside the block, or every system clock edge. Software stops it with a pause bit. It also stops while either of two processors is halted in debug, if that processor's debug-stop enable is set.

Reading or writing a 64-bit value through a 32-bit bus takes two transfers, and the counter can move between them. The block keeps both accesses coherent. A write to the low half only goes into a staging register. The later high-half write loads both halves into the counter together. A read of the low half returns the live low word and captures the high word at the same time, and the high-half read returns that captured word. Raw read addresses return the live halves with no capture. A one-way lock freezes every register until reset. The live low word is also driven out to a neighbouring alarm comparator.

Top module: `tbase_timer`

## Requirements
- R1: After reset the counter is 0, pause (0x30 bit 0) reads 0, lock (0x34 bit 0) reads 0, source (0x38 bit 0) reads 0, and the debug-stop register at 0x2C reads 0x6.
- R2: With source 0, the counter advances by one for each clock cycle in which tick_i is high, and carries from the low word into the high word.
- R3: With source 1, the counter advances by one on every clock cycle, so two reads of 0x28 two cycles apart differ by 2.
- R4: A write to 0x04 changes no counter bit. A write to 0x00 loads {pwdata, staged low word} into the counter. The staged low word keeps its value across later high-half writes.
- R5: A read of 0x0C returns the live low word and captures the live high word. A read of 0x08 returns the most recently captured high word.
- R6: Reads of 0x24 (high) and 0x28 (low) return the live counter halves and do not change the captured high word.
- R7: While 0x30 bit 0 is 1, the counter holds its value.
- R8: 0x2C bit 1 enables stopping while dbg_halt_i[0] is high, and bit 2 enables stopping while dbg_halt_i[1] is high. A halt whose enable bit is 0 does not stop the count.
- R9: Writing 1 to 0x34 bit 0 sets a lock that only reset clears. While the lock is set, every register write is ignored, including a write of 0 to 0x34.
- R10: A high-half load in a cycle with a count event loads the written value without adding the increment, so a read of 0x28 one cycle after the load returns the staged low word plus 1.
- R11: Every transfer completes in its access phase with pready_o 1 and pslverr_o 0. Reads of unmapped offsets and of the write-only offsets 0x00 and 0x04 return 0.
- R12: time_lo_o always equals the live low 32 bits of the counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| psel_i | input | 1 | APB select |
| penable_i | input | 1 | APB access phase |
| pwrite_i | input | 1 | APB write when 1 |
| paddr_i | input | 8 | APB byte address |
| pwdata_i | input | 32 | APB write data |
| prdata_o | output | 32 | APB read data |
| pready_o | output | 1 | Transfer complete, always 1 |
| pslverr_o | output | 1 | Transfer error, always 0 |
| tick_i | input | 1 | External count pulse, one cycle wide |
| dbg_halt_i | input | 2 | Debug-halt state of processor 0 and 1 |
| time_lo_o | output | 32 | Live low word of the counter |

## Verification
The assertions assume APB transfers follow the protocol: psel_i is held through a two-phase transfer and penable_i only rises one cycle after select. They also assume tick_i, dbg_halt_i and the bus inputs are synchronous to clk_i. The bench drives every input on the falling edge and issues transfers back to back, each lasting exactly two cycles, so the count between reads can be predicted. Tick pulses are one cycle wide. The bench changes debug halts only between transfers.

// File: rtl/tbase_pkg.sv
package tbase_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned NUM_DBG = 2;

  localparam logic [ADDR_W-1:0] OFF_WR_HI  = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_WR_LO  = 8'h04;
  localparam logic [ADDR_W-1:0] OFF_RD_HI  = 8'h08;
  localparam logic [ADDR_W-1:0] OFF_RD_LO  = 8'h0C;
  localparam logic [ADDR_W-1:0] OFF_RAW_HI = 8'h24;
  localparam logic [ADDR_W-1:0] OFF_RAW_LO = 8'h28;
  localparam logic [ADDR_W-1:0] OFF_DBG    = 8'h2C;
  localparam logic [ADDR_W-1:0] OFF_PAUSE  = 8'h30;
  localparam logic [ADDR_W-1:0] OFF_LOCK   = 8'h34;
  localparam logic [ADDR_W-1:0] OFF_SRC    = 8'h38;
endpackage

// File: rtl/tbase_gate.sv
module tbase_gate #(
  parameter int unsigned NDBG = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  input  logic            src_clk_i,
  input  logic            pause_i,
  input  logic [NDBG-1:0] dbg_en_i,
  input  logic [NDBG-1:0] halt_i,
  output logic            inc_o
);
  logic [NDBG-1:0] stop_v;

  for (genvar g = 0; g < NDBG; g++) begin : g_stop
    assign stop_v[g] = dbg_en_i[g] & halt_i[g];
  end

  assign inc_o = (src_clk_i | tick_i) & ~pause_i & ~(|stop_v);

  // R7 R8: any active stop source blocks the count event
  a_r7_pause_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pause_i |-> !inc_o);
  a_r8_dbg_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((dbg_en_i & halt_i) != '0) |-> !inc_o);
endmodule

// File: rtl/tbase_counter.sv
module tbase_counter #(
  parameter int unsigned CW = 64
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  input  logic          inc_i,
  output logic [CW-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_o <= '0;
    else if (load_i) cnt_o <= load_val_i;
    else if (inc_i)  cnt_o <= cnt_o + 1'b1;
  end

  a_r10_load_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cnt_o == $past(load_val_i));
  a_r2_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !load_i) |=> cnt_o == $past(cnt_o) + 1'b1);
  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inc_i && !load_i) |=> $stable(cnt_o));
endmodule

// File: rtl/tbase_regs.sv
module tbase_regs
  import tbase_pkg::*;
#(
  parameter int unsigned DW   = DATA_W,
  parameter int unsigned AW   = ADDR_W,
  parameter int unsigned NDBG = NUM_DBG
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            psel_i,
  input  logic            penable_i,
  input  logic            pwrite_i,
  input  logic [AW-1:0]   paddr_i,
  input  logic [DW-1:0]   pwdata_i,
  output logic [DW-1:0]   prdata_o,
  input  logic [2*DW-1:0] cnt_i,
  output logic            load_o,
  output logic [2*DW-1:0] load_val_o,
  output logic            pause_o,
  output logic [NDBG-1:0] dbg_en_o,
  output logic            src_clk_o
);
  localparam int unsigned DBG_HI = NDBG;

  logic          acc, wr, rd;
  logic [DW-1:0] stage_q, snap_q;
  logic          lock_q;

  assign acc = psel_i & penable_i;
  assign wr  = acc & pwrite_i & ~lock_q;
  assign rd  = acc & ~pwrite_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q   <= '0;
      snap_q    <= '0;
      pause_o   <= 1'b0;
      dbg_en_o  <= '1;
      lock_q    <= 1'b0;
      src_clk_o <= 1'b0;
    end else begin
      if (rd && paddr_i == OFF_RD_LO) snap_q <= cnt_i[2*DW-1:DW];
      if (wr) begin
        case (paddr_i)
          OFF_WR_LO: stage_q   <= pwdata_i;
          OFF_DBG:   dbg_en_o  <= pwdata_i[DBG_HI:1];
          OFF_PAUSE: pause_o   <= pwdata_i[0];
          OFF_LOCK:  lock_q    <= lock_q | pwdata_i[0];
          OFF_SRC:   src_clk_o <= pwdata_i[0];
          default: ;
        endcase
      end
    end
  end

  assign load_o     = wr && (paddr_i == OFF_WR_HI);
  assign load_val_o = {pwdata_i, stage_q};

  always_comb begin
    prdata_o = '0;
    if (rd) begin
      case (paddr_i)
        OFF_RD_HI:  prdata_o = snap_q;
        OFF_RD_LO:  prdata_o = cnt_i[DW-1:0];
        OFF_RAW_HI: prdata_o = cnt_i[2*DW-1:DW];
        OFF_RAW_LO: prdata_o = cnt_i[DW-1:0];
        OFF_DBG:    prdata_o[DBG_HI:1] = dbg_en_o;
        OFF_PAUSE:  prdata_o[0] = pause_o;
        OFF_LOCK:   prdata_o[0] = lock_q;
        OFF_SRC:    prdata_o[0] = src_clk_o;
        default: ;
      endcase
    end
  end

  a_r9_lock_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_q |=> lock_q);
  a_r9_lock_freezes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_q |=> ($stable(pause_o) && $stable(src_clk_o) && $stable(dbg_en_o) && $stable(stage_q)));
  a_r9_no_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_q |-> !load_o);
  a_r5_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && paddr_i == OFF_RD_LO) |=> snap_q == $past(cnt_i[2*DW-1:DW]));
  a_r6_raw_no_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && (paddr_i == OFF_RAW_HI || paddr_i == OFF_RAW_LO)) |=> $stable(snap_q));
endmodule

// File: rtl/tbase_timer.sv
module tbase_timer
  import tbase_pkg::*;
#(
  parameter int unsigned DW   = DATA_W,
  parameter int unsigned AW   = ADDR_W,
  parameter int unsigned NDBG = NUM_DBG
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            psel_i,
  input  logic            penable_i,
  input  logic            pwrite_i,
  input  logic [AW-1:0]   paddr_i,
  input  logic [DW-1:0]   pwdata_i,
  output logic [DW-1:0]   prdata_o,
  output logic            pready_o,
  output logic            pslverr_o,
  input  logic            tick_i,
  input  logic [NDBG-1:0] dbg_halt_i,
  output logic [DW-1:0]   time_lo_o
);
  localparam int unsigned CW = 2 * DW;

  logic [CW-1:0]   cnt, load_val;
  logic            load, inc, pause, src_clk;
  logic [NDBG-1:0] dbg_en;

  tbase_regs #(.DW(DW), .AW(AW), .NDBG(NDBG)) u_regs (
    .clk_i, .rst_ni, .psel_i, .penable_i, .pwrite_i, .paddr_i, .pwdata_i, .prdata_o,
    .cnt_i(cnt), .load_o(load), .load_val_o(load_val), .pause_o(pause),
    .dbg_en_o(dbg_en), .src_clk_o(src_clk)
  );

  tbase_gate #(.NDBG(NDBG)) u_gate (
    .clk_i, .rst_ni, .tick_i, .src_clk_i(src_clk), .pause_i(pause),
    .dbg_en_i(dbg_en), .halt_i(dbg_halt_i), .inc_o(inc)
  );

  tbase_counter #(.CW(CW)) u_cnt (
    .clk_i, .rst_ni, .load_i(load), .load_val_i(load_val), .inc_i(inc), .cnt_o(cnt)
  );

  assign pready_o  = 1'b1;
  assign pslverr_o = 1'b0;
  assign time_lo_o = cnt[DW-1:0];
endmodule

// File: tb/tbase_timer_tb.sv
module tbase_timer_tb;
  logic        clk = 0, rst_n = 0;
  logic        psel = 0, pen = 0, pwr = 0, tick = 0;
  logic [7:0]  paddr = 0;
  logic [31:0] pwdata = 0, prdata, tlo;
  logic        pready, pslverr;
  logic [1:0]  halt = 0;
  int          n_chk = 0, n_fail = 0;
  logic        done = 0;
  logic [31:0] last_tlo;
  logic        last_rdy, last_err;

  always #10 clk = ~clk;

  tbase_timer u_dut (
    .clk_i(clk), .rst_ni(rst_n), .psel_i(psel), .penable_i(pen), .pwrite_i(pwr),
    .paddr_i(paddr), .pwdata_i(pwdata), .prdata_o(prdata), .pready_o(pready),
    .pslverr_o(pslverr), .tick_i(tick), .dbg_halt_i(halt), .time_lo_o(tlo)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // transfers start and end on a falling edge, two cycles each
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    psel = 1; pen = 0; pwr = 1; paddr = a; pwdata = d;
    @(negedge clk); pen = 1;
    @(negedge clk); psel = 0; pen = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    psel = 1; pen = 0; pwr = 0; paddr = a;
    @(negedge clk); pen = 1;
    #1 d = prdata; last_tlo = tlo; last_rdy = pready; last_err = pslverr;
    @(negedge clk); psel = 0; pen = 0;
  endtask

  task automatic pulse(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1; @(negedge clk); tick = 0;
    end
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(8'h24, v); check(v == 0, "R1 raw hi", v, 0);
    rd(8'h28, v); check(v == 0, "R1 raw lo", v, 0);
    check(last_tlo == 0, "R12 time_lo at reset", last_tlo, 0);
    rd(8'h2C, v); check(v == 32'h6, "R1 dbg enables", v, 6);
    rd(8'h30, v); check(v == 0, "R1 pause", v, 0);
    rd(8'h34, v); check(v == 0, "R1 lock", v, 0);
    rd(8'h38, v); check(v == 0, "R1 source", v, 0);
  endtask

  task automatic t_tick();
    logic [31:0] v;
    pulse(5);
    rd(8'h28, v); check(v == 5, "R2 five ticks", v, 5);
  endtask

  task automatic t_clk();
    logic [31:0] a, b;
    wr(8'h38, 1);
    rd(8'h28, a); rd(8'h28, b);
    check(b - a == 2, "R3 clock source delta", b - a, 2);
    check(last_tlo == b, "R12 time_lo matches", last_tlo, b);
  endtask

  task automatic t_pause();
    logic [31:0] a, b;
    wr(8'h30, 1);
    rd(8'h28, a); rd(8'h28, b);
    check(b == a, "R7 paused hold", b, a);
    rd(8'h30, a); check(a == 1, "R7 pause readback", a, 1);
  endtask

  task automatic t_load();
    logic [31:0] a, h, l;
    rd(8'h28, a);
    wr(8'h04, 32'hFFFF_FFFE);
    rd(8'h28, l); check(l == a, "R4 low write staged only", l, a);
    wr(8'h00, 32'h12);
    rd(8'h24, h); rd(8'h28, l);
    check({h, l} == 64'h12_FFFF_FFFE, "R4 load", {h, l}, 64'h12_FFFF_FFFE);
    wr(8'h00, 32'h40);
    rd(8'h24, h); rd(8'h28, l);
    check({h, l} == 64'h40_FFFF_FFFE, "R4 stage persists", {h, l}, 64'h40_FFFF_FFFE);
    wr(8'h38, 0); wr(8'h30, 0);
    pulse(3);
    wr(8'h30, 1);
    rd(8'h24, h); rd(8'h28, l);
    check({h, l} == 64'h41_0000_0001, "R2 carry", {h, l}, 64'h41_0000_0001);
  endtask

  task automatic t_snap();
    logic [31:0] v;
    wr(8'h04, 32'h1234); wr(8'h00, 32'hAAAA);
    rd(8'h0C, v); check(v == 32'h1234, "R5 live low", v, 32'h1234);
    wr(8'h00, 32'hBBBB);
    rd(8'h24, v); check(v == 32'hBBBB, "R6 raw hi live", v, 32'hBBBB);
    rd(8'h28, v); check(v == 32'h1234, "R6 raw lo live", v, 32'h1234);
    rd(8'h08, v); check(v == 32'hAAAA, "R5 R6 captured hi", v, 32'hAAAA);
    rd(8'h0C, v); rd(8'h08, v);
    check(v == 32'hBBBB, "R5 recapture", v, 32'hBBBB);
  endtask

  task automatic t_prio();
    logic [31:0] v;
    wr(8'h38, 1); wr(8'h30, 0);
    wr(8'h04, 32'h100); wr(8'h00, 32'h5);
    rd(8'h28, v); check(v == 32'h101, "R10 load beats inc", v, 32'h101);
    rd(8'h24, v); check(v == 32'h5, "R10 high after load", v, 5);
  endtask

  task automatic t_dbg();
    logic [31:0] a, b;
    halt = 2'b01; rd(8'h28, a); rd(8'h28, b);
    check(b == a, "R8 halt0 stops", b, a);
    halt = 2'b10; rd(8'h28, a); rd(8'h28, b);
    check(b == a, "R8 halt1 stops", b, a);
    halt = 2'b00;
    wr(8'h2C, 32'h4);
    halt = 2'b01; rd(8'h28, a); rd(8'h28, b);
    check(b - a == 2, "R8 halt0 disabled", b - a, 2);
    halt = 2'b10; rd(8'h28, a); rd(8'h28, b);
    check(b == a, "R8 halt1 still enabled", b, a);
    halt = 2'b00;
    rd(8'h2C, a); check(a == 32'h4, "R8 enable readback", a, 4);
  endtask

  task automatic t_apb();
    logic [31:0] v;
    rd(8'h10, v); check(v == 0, "R11 unmapped", v, 0);
    check(last_rdy && !last_err, "R11 ready no error", {last_rdy, last_err}, 2'b10);
    rd(8'h04, v); check(v == 0, "R11 write-only low", v, 0);
    rd(8'h00, v); check(v == 0, "R11 write-only high", v, 0);
  endtask

  task automatic t_lock();
    logic [31:0] h, l, h2, l2, v;
    wr(8'h30, 1);
    wr(8'h34, 1);
    rd(8'h34, v); check(v == 1, "R9 lock set", v, 1);
    wr(8'h30, 0);
    rd(8'h30, v); check(v == 1, "R9 pause frozen", v, 1);
    rd(8'h24, h); rd(8'h28, l);
    wr(8'h04, 32'hDEAD); wr(8'h00, 32'hBEEF);
    rd(8'h24, h2); rd(8'h28, l2);
    check({h2, l2} == {h, l}, "R9 load blocked", {h2, l2}, {h, l});
    wr(8'h34, 0);
    rd(8'h34, v); check(v == 1, "R9 lock sticky", v, 1);
    rst_n = 0; @(negedge clk); rst_n = 1; @(negedge clk);
    rd(8'h34, v); check(v == 0, "R9 R1 reset clears lock", v, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1; @(negedge clk);
    t_reset(); t_tick(); t_clk(); t_pause(); t_load(); t_snap();
    t_prio(); t_dbg(); t_apb(); t_lock();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1; n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule